// File: doc/BRIEF.md
# Serial Controller Mode/Command Sequencer

This block is the register front end of a programmable serial controller. It connects an 8-bit processor bus to the controller's transmitter and receiver. The bus has a chip select, read and write strobes, and a control/data select line. Data accesses pass straight through: a data write becomes a one-cycle strobe towards the transmitter, and a data read returns the receiver's byte. Control accesses go to this block. A read returns a status byte, which the block builds from the flags that the serial units supply. A write is steered by a small state machine.

After a reset, the first control write is taken as the mode byte. A synchronous mode (low two bits zero) then needs one or two sync characters before commands are taken. An asynchronous mode goes straight to commands. The states are `ST_MODE` (waiting for the mode byte), `ST_SYNC1` (waiting for the first sync character), `ST_SYNC2` (waiting for the second sync character) and `ST_CMD` (taking commands). The transitions are:
- MODE→SYNC1: on a mode byte with bits[1:0]=00.
- MODE→CMD: on any other mode byte.
- SYNC1→CMD: when the mode byte's bit7 is 1 (single sync character).
- SYNC1→SYNC2: when bit7 is 0.
- SYNC2→CMD: on the second sync character.
- CMD→MODE: on a command with bit6 set (internal reset).
- Any state→MODE: on a qualified external reset.

The command register drives the modem handshake outputs and the enable controls. The external reset only counts once it has been held for a minimum number of clocks.

Top module: `sctl_front`

## Requirements
- R1: When `cs_n`=0, the bus is decoded by `cd_sel`.
  - A read with `cd_sel`=0 returns `rx_data` and pulses `rx_rd_stb` once.
  - A read with `cd_sel`=1 returns the status byte.
  - A write with `cd_sel`=0 pulses `tx_wr_stb` once, with `tx_data` holding the written byte.
  - `dout_oe` is 1 only while `cs_n`=0 and `rd_n`=0.
  - With `cs_n`=1, no access takes place.
- R2: `rst` takes effect only after it has been high for RST_MIN (6) consecutive clock edges. A shorter pulse leaves every register unchanged. A qualified reset clears the mode, sync and command registers and returns to `ST_MODE`.
- R3: In `ST_MODE`, a control write is stored as the mode byte and appears on `mode_out`.
- R4: A mode byte with bits[1:0]=00 is synchronous.
  - With bit7=1, the next control write is stored on `sync1_out`.
  - With bit7=0, the next two control writes are stored on `sync1_out` and then `sync2_out`.
  - `cfg_ready` stays 0 until the last sync character is stored. Any other mode byte sets `cfg_ready` at once.
- R5: In `ST_CMD`, a control write with bit6=0 loads the command register. The bits map to outputs as follows:
  - bit0 → `tx_en`
  - bit1=1 → `dtr_n`=0
  - bit2 → `rx_en`
  - bit3 → `brk_send`
  - bit5=1 → `rts_n`=0
  - bit7 → `hunt`
- R6: Command bit4 makes `err_clr` pulse for exactly one cycle. The bit is not held in the command register. The pulse clears status bits 3..5.
- R7: A command with bit6=1 has these effects:
  - it returns the sequencer to `ST_MODE`, so `cfg_ready` goes to 0;
  - it clears the command outputs, so `dtr_n`=`rts_n`=1 and the enables go to 0;
  - it clears the error and sync flags.
  The next control write is then a mode byte.
- R8: The status byte is laid out as follows:
  - bit0 = `tx_rdy_in`
  - bit1 = `rx_rdy_in`
  - bit2 = `tx_emp_in`
  - bit3 = parity flag
  - bit4 = overrun flag
  - bit5 = framing flag
  - bit6 = sync/break indication
  - bit7 = NOT `dsr_n_in`
- R9: A one-cycle pulse on `pe_evt`, `oe_evt` or `fe_evt` sets its status flag. The flag stays set until an error clear or a reset. If an event and a clear arrive in the same cycle, the event wins.
- R10: The source of status bit6 depends on the mode.
  - In asynchronous mode, bit6 follows `brk_det_in` directly.
  - In synchronous mode, bit6 is a latch that `sync_hit_in` sets and that a status read clears. `brk_det_in` is then ignored.
- R11: In synchronous mode, a `sync_hit_in` pulse clears `hunt`.
- R12: A strobe held low for many cycles produces exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | External reset, active high, qualified by hold time |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | 1 = control/status, 0 = data |
| din | input | 8 | Write data from bus |
| dout | output | 8 | Read data to bus |
| dout_oe | output | 1 | Bus drive enable (bus released when 0) |
| rx_data | input | 8 | Received byte from receiver |
| rx_rd_stb | output | 1 | One-cycle pulse: receiver byte taken |
| tx_data | output | 8 | Byte for transmitter |
| tx_wr_stb | output | 1 | One-cycle pulse: transmit byte written |
| tx_rdy_in | input | 1 | Transmitter ready flag |
| rx_rdy_in | input | 1 | Receiver ready flag |
| tx_emp_in | input | 1 | Transmitter empty flag |
| pe_evt | input | 1 | Parity error event pulse |
| oe_evt | input | 1 | Overrun error event pulse |
| fe_evt | input | 1 | Framing error event pulse |
| brk_det_in | input | 1 | Break detect level (asynchronous mode) |
| sync_hit_in | input | 1 | Sync match pulse (synchronous mode) |
| dsr_n_in | input | 1 | Modem data-set-ready, active low |
| dtr_n | output | 1 | Modem data-terminal-ready, active low |
| rts_n | output | 1 | Modem request-to-send, active low |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| brk_send | output | 1 | Force break on line |
| hunt | output | 1 | Sync search active |
| err_clr | output | 1 | One-cycle error flag clear pulse |
| cfg_ready | output | 1 | Sequencer is in the command state |
| mode_out | output | 8 | Stored mode byte |
| sync1_out | output | 8 | First stored sync character |
| sync2_out | output | 8 | Second stored sync character |

## Verification
Each strobe passes through one sampling register. The register that it updates is then written on the next edge, so the effect of a write shows up two clock edges after its strobe falls. The bench waits two negative edges after releasing the strobe before it samples any output. Read data and the drive enable are combinational, so they are sampled at the first negative edge after the read strobe falls. At that point a pending sync latch is still visible. The latch clears two edges later, and a second status read shows it cleared. Event pulses are held across exactly one rising edge, so they land in the flags on that edge. The reset boundary is checked with holds of five and six edges.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        ST_MODE  = 2'd0,
        ST_SYNC1 = 2'd1,
        ST_SYNC2 = 2'd2,
        ST_CMD   = 2'd3
    } cfg_state_e;

    // command byte bit positions
    localparam int CB_TXEN = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RXEN = 2;
    localparam int CB_BRK  = 3;
    localparam int CB_ERST = 4;
    localparam int CB_RTS  = 5;
    localparam int CB_IRST = 6;
    localparam int CB_HUNT = 7;

    // mode byte: single sync character select
    localparam int MB_ONE = 7;
endpackage

// File: rtl/sctl_rst_qual.sv
module sctl_rst_qual #(
    parameter int RST_MIN = 6
) (
    input  logic clk,
    input  logic rst,
    output logic rst_hit
);
    localparam int CW = $clog2(RST_MIN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(RST_MIN)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: reset acts on the RST_MIN-th consecutive edge with rst high
    assign rst_hit = rst && (cnt_q >= CW'(RST_MIN - 1));
endmodule

// File: rtl/sctl_strobe.sv
module sctl_strobe
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_hit,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cd_sel,
    input  logic [BUS_W-1:0] din,
    output logic             rd_evt,
    output logic             rd_cd,
    output logic             wr_evt,
    output logic             wr_cd,
    output logic [BUS_W-1:0] wr_dat
);
    logic rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst_hit) begin
            rd_q   <= 1'b1;
            wr_q   <= 1'b1;
            rd_evt <= 1'b0;
            wr_evt <= 1'b0;
            rd_cd  <= 1'b0;
            wr_cd  <= 1'b0;
            wr_dat <= '0;
        end else begin
            rd_q   <= rd_n;
            wr_q   <= wr_n;
            rd_evt <= rd_q && !rd_n && !cs_n;
            wr_evt <= wr_q && !wr_n && !cs_n;
            if (rd_q && !rd_n && !cs_n) begin
                rd_cd <= cd_sel;
            end
            if (wr_q && !wr_n && !cs_n) begin
                wr_cd  <= cd_sel;
                wr_dat <= din;
            end
        end
    end

    // R12
    wr_single_chk: assert property (@(posedge clk) disable iff (rst_hit)
        wr_evt |=> !wr_evt);
    // R12
    rd_single_chk: assert property (@(posedge clk) disable iff (rst_hit)
        rd_evt |=> !rd_evt);
endmodule

// File: rtl/sctl_cfg_fsm.sv
module sctl_cfg_fsm
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_hit,
    input  logic             wr_evt,
    input  logic             wr_cd,
    input  logic [BUS_W-1:0] wr_dat,
    input  logic             sync_hit,
    output logic             cfg_ready,
    output logic             is_sync,
    output logic [BUS_W-1:0] mode_q,
    output logic [BUS_W-1:0] sync1_q,
    output logic [BUS_W-1:0] sync2_q,
    output logic             tx_en,
    output logic             rx_en,
    output logic             brk_send,
    output logic             hunt,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             err_clr,
    output logic             int_rst
);
    cfg_state_e       state_q, state_d;
    logic [BUS_W-1:0] cmd_q;
    logic             ctl_wr;
    logic [BUS_W-1:0] keep_mask;

    assign ctl_wr    = wr_evt && wr_cd;
    assign keep_mask = ~((BUS_W'(1) << CB_ERST) | (BUS_W'(1) << CB_IRST));

    // state register
    always_ff @(posedge clk) begin
        if (rst_hit) begin
            state_q <= ST_MODE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MODE: begin
                if (ctl_wr) begin
                    state_d = (wr_dat[1:0] == 2'b00) ? ST_SYNC1 : ST_CMD;
                end
            end
            ST_SYNC1: begin
                if (ctl_wr) begin
                    state_d = mode_q[MB_ONE] ? ST_CMD : ST_SYNC2;
                end
            end
            ST_SYNC2: begin
                if (ctl_wr) begin
                    state_d = ST_CMD;
                end
            end
            ST_CMD: begin
                if (ctl_wr && wr_dat[CB_IRST]) begin
                    state_d = ST_MODE;
                end
            end
            default: state_d = ST_MODE;
        endcase
    end

    // registers written per state
    always_ff @(posedge clk) begin
        if (rst_hit) begin
            mode_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            cmd_q   <= '0;
            err_clr <= 1'b0;
            int_rst <= 1'b0;
        end else begin
            err_clr <= 1'b0;
            int_rst <= 1'b0;
            if (sync_hit && is_sync) begin
                cmd_q[CB_HUNT] <= 1'b0;
            end
            if (ctl_wr) begin
                unique case (state_q)
                    ST_MODE:  mode_q  <= wr_dat;
                    ST_SYNC1: sync1_q <= wr_dat;
                    ST_SYNC2: sync2_q <= wr_dat;
                    ST_CMD: begin
                        if (wr_dat[CB_IRST]) begin
                            cmd_q   <= '0;
                            int_rst <= 1'b1;
                        end else begin
                            cmd_q   <= wr_dat & keep_mask;
                            err_clr <= wr_dat[CB_ERST];
                        end
                    end
                    default: mode_q <= mode_q;
                endcase
            end
        end
    end

    assign cfg_ready = (state_q == ST_CMD);
    assign is_sync   = (mode_q[1:0] == 2'b00);
    assign tx_en     = cmd_q[CB_TXEN];
    assign rx_en     = cmd_q[CB_RXEN];
    assign brk_send  = cmd_q[CB_BRK];
    assign hunt      = cmd_q[CB_HUNT];
    assign dtr_n     = !cmd_q[CB_DTR];
    assign rts_n     = !cmd_q[CB_RTS];

    // R7
    irst_chk: assert property (@(posedge clk) disable iff (rst_hit)
        (ctl_wr && state_q == ST_CMD && wr_dat[CB_IRST])
            |=> (!cfg_ready && dtr_n && rts_n && !tx_en && !rx_en));
    // R6
    errclr_pulse_chk: assert property (@(posedge clk) disable iff (rst_hit)
        err_clr |=> !err_clr);
    // R4
    sync2_only_chk: assert property (@(posedge clk) disable iff (rst_hit)
        (state_q == ST_SYNC2) |-> (is_sync && !mode_q[MB_ONE]));
    // R11
    hunt_clr_chk: assert property (@(posedge clk) disable iff (rst_hit)
        (sync_hit && is_sync && !ctl_wr) |=> !hunt);
endmodule

// File: rtl/sctl_status.sv
module sctl_status
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_hit,
    input  logic             int_rst,
    input  logic             err_clr,
    input  logic             is_sync,
    input  logic             rd_evt,
    input  logic             rd_cd,
    input  logic             tx_rdy,
    input  logic             rx_rdy,
    input  logic             tx_emp,
    input  logic             pe_evt,
    input  logic             oe_evt,
    input  logic             fe_evt,
    input  logic             brk_det,
    input  logic             sync_hit,
    input  logic             dsr_n,
    output logic [BUS_W-1:0] stat
);
    localparam int NERR = 3;

    logic [NERR-1:0] evt_v, err_q;
    logic            clr_all, syn_q;

    assign evt_v   = {fe_evt, oe_evt, pe_evt};
    assign clr_all = rst_hit || int_rst;

    for (genvar g = 0; g < NERR; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (clr_all) begin
                err_q[g] <= 1'b0;
            end else if (evt_v[g]) begin
                err_q[g] <= 1'b1;
            end else if (err_clr) begin
                err_q[g] <= 1'b0;
            end
        end

        // R9
        err_rise_chk: assert property (@(posedge clk) disable iff (rst_hit)
            $rose(err_q[g]) |-> $past(evt_v[g]));
    end

    always_ff @(posedge clk) begin
        if (clr_all) begin
            syn_q <= 1'b0;
        end else if (sync_hit && is_sync) begin
            syn_q <= 1'b1;
        end else if (rd_evt && rd_cd) begin
            syn_q <= 1'b0;
        end
    end

    assign stat = {!dsr_n, (is_sync ? syn_q : brk_det), err_q, tx_emp, rx_rdy, tx_rdy};

    // R10
    syn_rdclr_chk: assert property (@(posedge clk) disable iff (rst_hit)
        (rd_evt && rd_cd && !(sync_hit && is_sync)) |=> !syn_q);
endmodule

// File: rtl/sctl_front.sv
module sctl_front
    import sctl_pkg::*;
#(
    parameter int RST_MIN = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cd_sel,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] dout,
    output logic             dout_oe,
    input  logic [BUS_W-1:0] rx_data,
    output logic             rx_rd_stb,
    output logic [BUS_W-1:0] tx_data,
    output logic             tx_wr_stb,
    input  logic             tx_rdy_in,
    input  logic             rx_rdy_in,
    input  logic             tx_emp_in,
    input  logic             pe_evt,
    input  logic             oe_evt,
    input  logic             fe_evt,
    input  logic             brk_det_in,
    input  logic             sync_hit_in,
    input  logic             dsr_n_in,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             tx_en,
    output logic             rx_en,
    output logic             brk_send,
    output logic             hunt,
    output logic             err_clr,
    output logic             cfg_ready,
    output logic [BUS_W-1:0] mode_out,
    output logic [BUS_W-1:0] sync1_out,
    output logic [BUS_W-1:0] sync2_out
);
    logic             rst_hit;
    logic             rd_evt, rd_cd, wr_evt, wr_cd;
    logic [BUS_W-1:0] wr_dat, stat;
    logic             is_sync, int_rst;

    sctl_rst_qual #(.RST_MIN(RST_MIN)) u_rq (
        .clk     (clk),
        .rst     (rst),
        .rst_hit (rst_hit)
    );

    sctl_strobe u_stb (
        .clk     (clk),
        .rst_hit (rst_hit),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .cd_sel  (cd_sel),
        .din     (din),
        .rd_evt  (rd_evt),
        .rd_cd   (rd_cd),
        .wr_evt  (wr_evt),
        .wr_cd   (wr_cd),
        .wr_dat  (wr_dat)
    );

    sctl_cfg_fsm u_fsm (
        .clk       (clk),
        .rst_hit   (rst_hit),
        .wr_evt    (wr_evt),
        .wr_cd     (wr_cd),
        .wr_dat    (wr_dat),
        .sync_hit  (sync_hit_in),
        .cfg_ready (cfg_ready),
        .is_sync   (is_sync),
        .mode_q    (mode_out),
        .sync1_q   (sync1_out),
        .sync2_q   (sync2_out),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .brk_send  (brk_send),
        .hunt      (hunt),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .err_clr   (err_clr),
        .int_rst   (int_rst)
    );

    sctl_status u_st (
        .clk      (clk),
        .rst_hit  (rst_hit),
        .int_rst  (int_rst),
        .err_clr  (err_clr),
        .is_sync  (is_sync),
        .rd_evt   (rd_evt),
        .rd_cd    (rd_cd),
        .tx_rdy   (tx_rdy_in),
        .rx_rdy   (rx_rdy_in),
        .tx_emp   (tx_emp_in),
        .pe_evt   (pe_evt),
        .oe_evt   (oe_evt),
        .fe_evt   (fe_evt),
        .brk_det  (brk_det_in),
        .sync_hit (sync_hit_in),
        .dsr_n    (dsr_n_in),
        .stat     (stat)
    );

    // R1: bus decode
    assign dout_oe   = !cs_n && !rd_n;
    assign dout      = cd_sel ? stat : rx_data;
    assign rx_rd_stb = rd_evt && !rd_cd;
    assign tx_wr_stb = wr_evt && !wr_cd;
    assign tx_data   = wr_dat;

    // R1
    txstb_chk: assert property (@(posedge clk) disable iff (rst_hit)
        tx_wr_stb |=> !tx_wr_stb);
endmodule

// File: tb/sim_sctl_front.sv
module sim_sctl_front;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_sel = 1'b0;
    logic [7:0] din = '0, rx_data = '0;
    logic       tx_rdy_in = 0, rx_rdy_in = 0, tx_emp_in = 0;
    logic       pe_evt = 0, oe_evt = 0, fe_evt = 0, brk_det_in = 0, sync_hit_in = 0, dsr_n_in = 1;
    logic [7:0] dout, tx_data, mode_out, sync1_out, sync2_out;
    logic       dout_oe, rx_rd_stb, tx_wr_stb, dtr_n, rts_n, tx_en, rx_en, brk_send, hunt, err_clr, cfg_ready;

    sctl_front u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd_sel(cd_sel),
        .din(din), .dout(dout), .dout_oe(dout_oe), .rx_data(rx_data), .rx_rd_stb(rx_rd_stb),
        .tx_data(tx_data), .tx_wr_stb(tx_wr_stb), .tx_rdy_in(tx_rdy_in), .rx_rdy_in(rx_rdy_in),
        .tx_emp_in(tx_emp_in), .pe_evt(pe_evt), .oe_evt(oe_evt), .fe_evt(fe_evt),
        .brk_det_in(brk_det_in), .sync_hit_in(sync_hit_in), .dsr_n_in(dsr_n_in),
        .dtr_n(dtr_n), .rts_n(rts_n), .tx_en(tx_en), .rx_en(rx_en), .brk_send(brk_send),
        .hunt(hunt), .err_clr(err_clr), .cfg_ready(cfg_ready), .mode_out(mode_out),
        .sync1_out(sync1_out), .sync2_out(sync2_out)
    );

    int checks = 0, fails = 0;
    int tx_cnt = 0, rd_cnt = 0, ec_cnt = 0;
    logic [7:0] tx_last = '0;
    bit done = 0;

    always @(posedge clk) begin
        if (tx_wr_stb) begin tx_cnt++; tx_last <= tx_data; end
        if (rx_rd_stb) rd_cnt++;
        if (err_clr) ec_cnt++;
    end

    // command byte, expected {tx_en, dtr_n, rx_en, brk_send, rts_n, hunt}
    localparam logic [13:0] CMD_VEC [8] = '{
        {8'h01, 6'b110010},
        {8'h02, 6'b000010},
        {8'h04, 6'b011010},
        {8'h08, 6'b010110},
        {8'h20, 6'b010000},
        {8'h80, 6'b010011},
        {8'h10, 6'b010010},
        {8'hAF, 6'b101101}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic cd, input logic [7:0] d, input int hold);
        @(negedge clk);
        cs_n = 0; cd_sel = cd; din = d; wr_n = 0;
        cyc(hold);
        wr_n = 1; cs_n = 1;
        cyc(2);
    endtask

    task automatic bus_rd(input logic cd, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 0; cd_sel = cd; rd_n = 0;
        cyc(1);
        d = dout; oe = dout_oe;
        rd_n = 1; cs_n = 1;
        cyc(2);
    endtask

    task automatic do_rst(input int n);
        @(negedge clk);
        rst = 1;
        cyc(n);
        rst = 0;
        cyc(1);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic       oe;
        int         n0, e0;

        cyc(8);
        rst = 0;
        cyc(1);
        // R2 reset state
        chk("R2 reset outputs", {cfg_ready, dtr_n, rts_n, tx_en, dout_oe}, 5'b01100);

        // R3/R4 asynchronous mode byte goes straight to commands
        bus_wr(1, 8'h4E, 2);
        chk("R3 mode stored", mode_out, 8'h4E);
        chk("R4 async ready", cfg_ready, 1);

        // R5/R6 command table
        for (int i = 0; i < 8; i++) begin
            e0 = ec_cnt;
            bus_wr(1, CMD_VEC[i][13:6], 2);
            chk("R5 command outputs", {tx_en, dtr_n, rx_en, brk_send, rts_n, hunt}, CMD_VEC[i][5:0]);
            chk("R6 err_clr pulses", ec_cnt - e0, CMD_VEC[i][13:6] == 8'h10 ? 1 : (CMD_VEC[i][13:6] == 8'h10 ? 1 : 0));
        end

        // R1/R12 data write, strobe held four cycles
        n0 = tx_cnt;
        bus_wr(0, 8'h5A, 4);
        chk("R12 one tx strobe", tx_cnt - n0, 1);
        chk("R1 tx data", tx_last, 8'h5A);
        // R1 write with chip select high is ignored
        @(negedge clk);
        cs_n = 1; cd_sel = 1; din = 8'h40; wr_n = 0;
        cyc(3);
        wr_n = 1;
        cyc(2);
        chk("R1 deselected write", {tx_cnt - n0, cfg_ready}, {32'd1, 1'b1});

        // R1 data read
        rx_data = 8'h3C;
        n0 = rd_cnt;
        bus_rd(0, rv, oe);
        chk("R1 read data", rv, 8'h3C);
        chk("R1 drive enable", oe, 1);
        chk("R1 rx strobe", rd_cnt - n0, 1);

        // R8/R10 status layout, async bit6 follows break detect
        tx_rdy_in = 1; tx_emp_in = 1; dsr_n_in = 0; brk_det_in = 1;
        bus_rd(1, rv, oe);
        chk("R8 status layout", rv, 8'hC5);

        // R9 error latching
        @(negedge clk); pe_evt = 1; oe_evt = 1;
        @(negedge clk); pe_evt = 0; oe_evt = 0;
        cyc(2);
        bus_rd(1, rv, oe);
        chk("R9 parity+overrun latched", rv, 8'hDD);
        @(negedge clk); fe_evt = 1;
        @(negedge clk); fe_evt = 0;
        rx_rdy_in = 1;
        bus_rd(1, rv, oe);
        chk("R9 framing latched", rv, 8'hFF);
        rx_rdy_in = 0;
        bus_wr(1, 8'h10, 2);
        bus_rd(1, rv, oe);
        chk("R6 error clear", rv, 8'hC5);

        // R7 internal reset
        bus_wr(1, 8'h23, 2);
        chk("R5 tx/dtr/rts", {tx_en, dtr_n, rts_n}, 3'b100);
        @(negedge clk); pe_evt = 1;
        @(negedge clk); pe_evt = 0;
        bus_wr(1, 8'h40, 2);
        chk("R7 back to mode wait", {cfg_ready, dtr_n, rts_n, tx_en}, 4'b0110);
        bus_rd(1, rv, oe);
        chk("R7 flags cleared", rv, 8'hC5);

        // R4 two sync characters
        bus_wr(1, 8'h00, 2);
        chk("R4 sync mode waits", cfg_ready, 0);
        bus_wr(1, 8'h16, 2);
        chk("R4 waits second sync", cfg_ready, 0);
        bus_wr(1, 8'h17, 2);
        chk("R4 ready after sync2", cfg_ready, 1);
        chk("R4 sync chars", {sync1_out, sync2_out}, 16'h1617);

        // R11/R10 hunt and sync latch
        bus_wr(1, 8'h80, 2);
        chk("R5 hunt set", hunt, 1);
        bus_rd(1, rv, oe);
        chk("R10 break ignored in sync", rv, 8'h85);
        @(negedge clk); sync_hit_in = 1;
        @(negedge clk); sync_hit_in = 0;
        chk("R11 hunt cleared", hunt, 0);
        bus_rd(1, rv, oe);
        chk("R10 sync latched", rv, 8'hC5);
        bus_rd(1, rv, oe);
        chk("R10 sync cleared by read", rv, 8'h85);

        // R2 reset hold boundary
        do_rst(5);
        chk("R2 short reset ignored", {cfg_ready, sync1_out}, 9'h116);
        do_rst(6);
        chk("R2 full reset", {cfg_ready, dtr_n, sync1_out, sync2_out}, {2'b01, 16'h0000});

        // R4 single sync character
        bus_wr(1, 8'h80, 2);
        chk("R4 single sync waits", cfg_ready, 0);
        bus_wr(1, 8'h33, 2);
        chk("R4 single sync ready", {cfg_ready, sync1_out}, 9'h133);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule